// File: doc/BRIEF.md
# Four-Channel Programmable Chip Select Decoder

This block turns each bus cycle into up to four active-low chip selects. Each channel holds two 32-bit registers: a base register and a mask register. The base register gives the region's upper address bits and a function code, plus a valid flag and a flag that blocks CPU-space cycles. The mask register gives a per-bit don't-care pattern for the address and for the function code. It also holds the port-size and acknowledge-delay codes that the bus controller applies to cycles hitting that channel.

While the address strobe is high, every channel compares address bits 31..8 and the 4-bit function code against its base register, ignoring each bit that is set in the mask. Because the mask works bit by bit, one channel can cover several separate windows of the address map. The chip selects are registered, and the port-size and delay codes of the lowest-numbered asserting channel are registered beside them. Software programs the registers through a single-cycle write port and can read them back through a combinational read port.

Top module: `csel_unit`

## Requirements
- R1: Synchronous active-low reset drives every `cs_n` bit high and `port_size`/`ack_delay` to 0. It clears base bit 0 (valid) and base bit 1 (no-CPU-space) in every channel, and leaves all other base bits and all mask bits unchanged.
- R2: A channel matches only when `((bus_addr ^ base) & ~mask)` is zero over bits 31..8, where base bits 31..8 hold the base address and mask bits 31..8 the address mask. Address bits 7..0 never affect the match.
- R3: Address mask bits may be set in any pattern. A channel with k set bits in mask 31..8 decodes 2^(k+8) bytes spread over every region those don't-care bits reach.
- R4: The function code must also satisfy `((bus_fc ^ base[7:4]) & ~mask[7:4]) == 0`. Mask bits 7..4 mask FC3..FC0 one for one.
- R5: When base bit 1 is set, a channel never asserts for function code 4'h7 or 4'hF. When that bit is clear, such cycles decode like any other.
- R6: A channel with base bit 0 clear never asserts.
- R7: `cs_n` reflects the compare sampled at a rising edge with `bus_strobe` high and is visible after that edge. After an edge that samples `bus_strobe` low, all `cs_n` bits are high.
- R8: Every matching channel asserts. `port_size` and `ack_delay` come from the lowest-numbered asserting channel.
- R9: `port_size` is that channel's mask bits 1..0 and `ack_delay` its mask bits 3..2. Both are 0 when no channel asserts.
- R10: A write with `reg_wr_sel`=0 targets the base register and `reg_wr_sel`=1 the mask register of channel `reg_wr_chan`. `reg_rd_data` returns the stored 32-bit value chosen by `reg_rd_chan`/`reg_rd_sel`.
- R11: A mask register may be rewritten while its channel is in use. The compare at the edge after the write uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_chan | input | 2 | Channel written |
| reg_wr_sel | input | 1 | 0 = base register, 1 = mask register |
| reg_wr_data | input | 32 | Write data |
| reg_rd_chan | input | 2 | Channel read |
| reg_rd_sel | input | 1 | 0 = base register, 1 = mask register |
| reg_rd_data | output | 32 | Read data (combinational) |
| bus_strobe | input | 1 | Address strobe, high while a cycle is valid |
| bus_addr | input | 32 | Bus address |
| bus_fc | input | 4 | Bus function code |
| cs_n | output | 4 | Active-low chip selects, one per channel |
| port_size | output | 2 | Port-size code of the lowest asserting channel |
| ack_delay | output | 2 | Acknowledge-delay code of the lowest asserting channel |

## Verification
The bench targets the cases that are easiest to get wrong. The first is a split mask whose don't-care bits sit far apart: a design using a contiguous size field would miss the upper window or hit the gap between the windows. The second is two channels hitting the same cycle: a wrong priority encoder would return the higher channel's size and delay codes. The third is the CPU-space block for both 4'h7 and 4'hF: checking only FC3..FC0 == 7 would let 4'hF through. Reset is checked to clear only the valid and no-CPU-space bits, and a mask rewritten during a held strobe must take effect on the very next edge.

// File: rtl/csel_pkg.sv
// Package: shared field positions and widths for the chip select unit.
// Assumes 32-bit registers with the compare field above bit 7.
package csel_pkg;
    parameter int REG_W    = 32;
    parameter int FC_W     = 4;
    parameter int CMP_LSB  = 8;
    parameter int FC_LSB   = 4;
    parameter int DLY_LSB  = 2;
    parameter int PSZ_LSB  = 0;
    parameter int CODE_W   = 2;
    parameter int VLD_BIT  = 0;
    parameter int NCS_BIT  = 1;
    localparam int CMP_W   = REG_W - CMP_LSB;

    typedef enum logic {
        REG_BASE = 1'b0,
        REG_MASK = 1'b1
    } reg_sel_e;

    // True for the two CPU-space function codes (4'h7 and 4'hF).
    function automatic logic is_cpu_space(input logic [FC_W-1:0] fc);
        return (fc[FC_W-2:0] == '1);
    endfunction
endpackage

// File: rtl/csel_regfile.sv
// Register file: one base and one mask register per channel.
// Assumes a single-cycle write; reads are combinational.
// Reset clears only the valid and no-CPU-space bits of each base register.
module csel_regfile
    import csel_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CH_W-1:0]              wr_chan,
    input  logic                         wr_sel,
    input  logic [REG_W-1:0]             wr_data,
    input  logic [CH_W-1:0]              rd_chan,
    input  logic                         rd_sel,
    output logic [REG_W-1:0]             rd_data,
    output logic [NUM_CH-1:0][REG_W-1:0] base_q,
    output logic [NUM_CH-1:0][REG_W-1:0] mask_q
);
    reg_sel_e wsel;
    reg_sel_e rsel;
    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic base_we;
        logic mask_we;
        assign base_we = wr_en && (wr_chan == CH_W'(ch)) && (wsel == REG_BASE);
        assign mask_we = wr_en && (wr_chan == CH_W'(ch)) && (wsel == REG_MASK);

        // Base register: reset clears control bits only, write loads all bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[ch][VLD_BIT] <= 1'b0;
                base_q[ch][NCS_BIT] <= 1'b0;
            end else if (base_we) begin
                base_q[ch] <= wr_data;
            end
        end

        // Mask register: untouched by reset, loaded on write.
        always_ff @(posedge clk) begin
            if (mask_we) begin
                mask_q[ch] <= wr_data;
            end
        end
    end

    // Read mux: pick the stored register chosen by channel and select.
    always_comb begin
        rd_data = (rsel == REG_MASK) ? mask_q[rd_chan] : base_q[rd_chan];
    end
endmodule

// File: rtl/csel_chan_match.sv
// One channel's compare: masked address, masked function code,
// valid gate and CPU-space suppression. Purely combinational.
module csel_chan_match
    import csel_pkg::*;
(
    input  logic [CMP_W-1:0] addr_hi,
    input  logic [FC_W-1:0]  fc,
    input  logic [CMP_W-1:0] base_addr,
    input  logic [FC_W-1:0]  base_fc,
    input  logic [CMP_W-1:0] addr_mask,
    input  logic [FC_W-1:0]  fc_mask,
    input  logic             valid,
    input  logic             no_cpu,
    output logic             hit
);
    logic addr_ok;
    logic fc_ok;
    logic blocked;

    // Compare: set mask bits become don't-cares.
    always_comb begin
        addr_ok = (((addr_hi ^ base_addr) & ~addr_mask) == '0);
        fc_ok   = (((fc ^ base_fc) & ~fc_mask) == '0);
        blocked = no_cpu && is_cpu_space(fc);
        hit     = valid && addr_ok && fc_ok && !blocked;
    end
endmodule

// File: rtl/csel_out_stage.sv
// Output stage: registers the chip selects while the strobe is high and
// picks size/delay codes from the lowest-numbered hitting channel.
// Assumes hit[] is already gated by valid and CPU-space rules.
module csel_out_stage
    import csel_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          strobe,
    input  logic [NUM_CH-1:0]             hit,
    input  logic [NUM_CH-1:0][CODE_W-1:0] ch_psz,
    input  logic [NUM_CH-1:0][CODE_W-1:0] ch_dly,
    output logic [NUM_CH-1:0]             cs_n,
    output logic [CODE_W-1:0]             port_size,
    output logic [CODE_W-1:0]             ack_delay
);
    logic [CODE_W-1:0] sel_psz;
    logic [CODE_W-1:0] sel_dly;

    // Priority pick: scan from the top so the lowest hitting channel wins.
    always_comb begin
        sel_psz = '0;
        sel_dly = '0;
        for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
            if (hit[ch]) begin
                sel_psz = ch_psz[ch];
                sel_dly = ch_dly[ch];
            end
        end
    end

    // Output register: follow the compare under strobe, idle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n      <= '1;
            port_size <= '0;
            ack_delay <= '0;
        end else if (strobe) begin
            cs_n      <= ~hit;
            port_size <= sel_psz;
            ack_delay <= sel_dly;
        end else begin
            cs_n      <= '1;
            port_size <= '0;
            ack_delay <= '0;
        end
    end

    // R7: no chip select without a strobe at the previous edge.
    p_cs_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |-> $past(strobe));

    // R7: a dropped strobe idles every select.
    p_idle_after_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(strobe) |-> (cs_n == '1));

    // R9: codes are zero when nothing is selected.
    p_codes_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == '1) |-> (port_size == '0 && ack_delay == '0));
endmodule

// File: rtl/csel_unit.sv
// Top: four-channel programmable chip select decoder.
// Ties the register file, per-channel compares and output stage together.
// Assumes address bits below CMP_LSB never take part in decoding.
module csel_unit
    import csel_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [CH_W-1:0]   reg_wr_chan,
    input  logic              reg_wr_sel,
    input  logic [REG_W-1:0]  reg_wr_data,
    input  logic [CH_W-1:0]   reg_rd_chan,
    input  logic              reg_rd_sel,
    output logic [REG_W-1:0]  reg_rd_data,
    input  logic              bus_strobe,
    input  logic [REG_W-1:0]  bus_addr,
    input  logic [FC_W-1:0]   bus_fc,
    output logic [NUM_CH-1:0] cs_n,
    output logic [CODE_W-1:0] port_size,
    output logic [CODE_W-1:0] ack_delay
);
    logic [NUM_CH-1:0][REG_W-1:0]  base_q;
    logic [NUM_CH-1:0][REG_W-1:0]  mask_q;
    logic [NUM_CH-1:0]             hit;
    logic [NUM_CH-1:0][CODE_W-1:0] ch_psz;
    logic [NUM_CH-1:0][CODE_W-1:0] ch_dly;
    logic                          unused_addr_low;

    assign unused_addr_low = ^bus_addr[CMP_LSB-1:0];

    csel_regfile #(.NUM_CH(NUM_CH)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_chan (reg_wr_chan),
        .wr_sel  (reg_wr_sel),
        .wr_data (reg_wr_data),
        .rd_chan (reg_rd_chan),
        .rd_sel  (reg_rd_sel),
        .rd_data (reg_rd_data),
        .base_q  (base_q),
        .mask_q  (mask_q)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_match
        csel_chan_match match_i (
            .addr_hi   (bus_addr[REG_W-1:CMP_LSB]),
            .fc        (bus_fc),
            .base_addr (base_q[ch][REG_W-1:CMP_LSB]),
            .base_fc   (base_q[ch][FC_LSB +: FC_W]),
            .addr_mask (mask_q[ch][REG_W-1:CMP_LSB]),
            .fc_mask   (mask_q[ch][FC_LSB +: FC_W]),
            .valid     (base_q[ch][VLD_BIT]),
            .no_cpu    (base_q[ch][NCS_BIT]),
            .hit       (hit[ch])
        );

        assign ch_psz[ch] = mask_q[ch][PSZ_LSB +: CODE_W];
        assign ch_dly[ch] = mask_q[ch][DLY_LSB +: CODE_W];

        // R6: an asserted select implies the channel was valid.
        p_valid_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !cs_n[ch] |-> $past(base_q[ch][VLD_BIT]));

        // R5: no select on a suppressed CPU-space cycle.
        p_cpu_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !cs_n[ch] |-> !($past(base_q[ch][NCS_BIT]) &&
                            ($past(bus_fc) == 4'h7 || $past(bus_fc) == 4'hF)));
    end

    csel_out_stage #(.NUM_CH(NUM_CH)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (bus_strobe),
        .hit       (hit),
        .ch_psz    (ch_psz),
        .ch_dly    (ch_dly),
        .cs_n      (cs_n),
        .port_size (port_size),
        .ack_delay (ack_delay)
    );
endmodule

// File: tb/csel_unit_tb.sv
// Directed bench for csel_unit: one task per scenario, each self-checking.
module csel_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_chan = '0;
    logic        reg_wr_sel = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_chan = '0;
    logic        reg_rd_sel = 1'b0;
    logic [31:0] reg_rd_data;
    logic        bus_strobe = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [3:0]  bus_fc = '0;
    logic [3:0]  cs_n;
    logic [1:0]  port_size;
    logic [1:0]  ack_delay;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] base_sh [4];
    logic [31:0] mask_sh [4];

    always #2 clk = ~clk;

    csel_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_chan(reg_wr_chan),
        .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_chan(reg_rd_chan), .reg_rd_sel(reg_rd_sel),
        .reg_rd_data(reg_rd_data),
        .bus_strobe(bus_strobe), .bus_addr(bus_addr), .bus_fc(bus_fc),
        .cs_n(cs_n), .port_size(port_size), .ack_delay(ack_delay)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Spec model of one decode: returns {cs_n, port_size, ack_delay}.
    function automatic logic [7:0] model(input logic [31:0] a, input logic [3:0] f);
        logic [3:0] cs;
        logic [1:0] ps;
        logic [1:0] dl;
        bit found;
        cs = 4'hF; ps = 0; dl = 0; found = 0;
        for (int c = 0; c < 4; c++) begin
            bit m;
            m = base_sh[c][0]
                && (((a[31:8] ^ base_sh[c][31:8]) & ~mask_sh[c][31:8]) == 0)
                && (((f ^ base_sh[c][7:4]) & ~mask_sh[c][7:4]) == 0)
                && !(base_sh[c][1] && (f == 4'h7 || f == 4'hF));
            if (m) begin
                cs[c] = 1'b0;
                if (!found) begin
                    ps = mask_sh[c][1:0];
                    dl = mask_sh[c][3:2];
                    found = 1;
                end
            end
        end
        return {cs, ps, dl};
    endfunction

    task automatic write_reg(input int ch, input bit sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_chan = 2'(ch); reg_wr_sel = sel; reg_wr_data = d;
        @(posedge clk);
        if (sel) mask_sh[ch] = d; else base_sh[ch] = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_check(input string req, input int ch, input bit sel, input logic [31:0] exp);
        @(negedge clk);
        reg_rd_chan = 2'(ch); reg_rd_sel = sel;
        #1;
        check(req, reg_rd_data, exp);
    endtask

    // One strobed cycle, then strobe removed; checks both phases.
    task automatic bus_cycle(input string req, input logic [31:0] a, input logic [3:0] f);
        @(negedge clk);
        bus_strobe = 1'b1; bus_addr = a; bus_fc = f;
        @(posedge clk);
        @(negedge clk);
        check(req, {24'h0, cs_n, port_size, ack_delay}, {24'h0, model(a, f)});
        bus_strobe = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7 idle after strobe drop", {28'h0, cs_n}, 32'hF);
    endtask

    task automatic t_reset_idle;
        check("R1 cs_n after reset", {28'h0, cs_n}, 32'hF);
        check("R1 codes after reset", {28'h0, port_size, ack_delay}, 32'h0);
    endtask

    task automatic t_program;
        write_reg(0, 0, 32'h0001_0051); write_reg(0, 1, 32'h0000_FF06);
        write_reg(1, 0, 32'h0080_0003); write_reg(1, 1, 32'h0010_0FF9);
        write_reg(2, 0, 32'h0001_0043); write_reg(2, 1, 32'h0000_FF3F);
        write_reg(3, 0, 32'h0020_0000); write_reg(3, 1, 32'h0000_0000);
    endtask

    task automatic t_readback;
        read_check("R10 base ch0", 0, 0, 32'h0001_0051);
        read_check("R10 mask ch1", 1, 1, 32'h0010_0FF9);
        read_check("R10 base ch2", 2, 0, 32'h0001_0043);
        read_check("R10 mask ch2", 2, 1, 32'h0000_FF3F);
    endtask

    task automatic t_addr_match;
        bus_cycle("R2 low addr bits ignored", 32'h0001_00FF, 4'h5);
        bus_cycle("R2 masked bits inside window", 32'h0001_AB12, 4'h5);
        bus_cycle("R2 outside window", 32'h0002_0000, 4'h5);
    endtask

    task automatic t_split_mask;
        bus_cycle("R3 lower window", 32'h0080_0ABC, 4'h2);
        bus_cycle("R3 upper window", 32'h0090_0ABC, 4'h2);
        bus_cycle("R3 gap between windows", 32'h0080_1000, 4'h2);
        bus_cycle("R3 unmasked bit differs", 32'h00A0_0000, 4'h2);
    endtask

    task automatic t_fc_match;
        bus_cycle("R4 fc under mask", 32'h0001_0000, 4'h6);
        bus_cycle("R4 fc mismatch", 32'h0001_0000, 4'h3);
    endtask

    task automatic t_cpu_space;
        bus_cycle("R5 fc 7 blocked", 32'h0080_0000, 4'h7);
        bus_cycle("R5 fc F blocked", 32'h0080_0000, 4'hF);
        check("R5 fc F gives no select", {28'h0, cs_n}, 32'hF);
        write_reg(1, 0, 32'h0080_0001);
        bus_cycle("R5 fc 7 allowed when bit clear", 32'h0080_0000, 4'h7);
    endtask

    task automatic t_valid;
        bus_cycle("R6 invalid channel silent", 32'h0020_0000, 4'h0);
        write_reg(3, 0, 32'h0020_0001);
        bus_cycle("R6 channel asserts once valid", 32'h0020_0000, 4'h0);
    endtask

    task automatic t_priority;
        bus_cycle("R8 overlap ch0 and ch2", 32'h0001_0000, 4'h5);
        check("R8 both selects low", {28'h0, model(32'h0001_0000, 4'h5)[7:4]}, 32'hA);
        check("R9 codes from ch0", {28'h0, model(32'h0001_0000, 4'h5)[3:0]}, 32'h9);
        bus_cycle("R9 ch2 only codes", 32'h0001_0000, 4'h6);
        bus_cycle("R9 no hit codes zero", 32'h7000_0000, 4'h1);
    endtask

    task automatic t_timing;
        @(negedge clk);
        bus_strobe = 1'b1; bus_addr = 32'h0001_0000; bus_fc = 4'h5;
        #1;
        check("R7 no select before edge", {28'h0, cs_n}, 32'hF);
        @(posedge clk);
        @(negedge clk);
        check("R7 select after edge", {28'h0, cs_n}, 32'hA);
        @(posedge clk);
        @(negedge clk);
        check("R7 held while strobe high", {28'h0, cs_n}, 32'hA);
        bus_strobe = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7 release after strobe low", {28'h0, cs_n, port_size, ack_delay}, 32'hF0);
    endtask

    task automatic t_live_mask;
        @(negedge clk);
        bus_strobe = 1'b1; bus_addr = 32'h0003_0000; bus_fc = 4'h5;
        @(posedge clk);
        @(negedge clk);
        check("R11 miss before rewrite", {28'h0, cs_n}, 32'hF);
        reg_wr_en = 1'b1; reg_wr_chan = 2'd0; reg_wr_sel = 1'b1; reg_wr_data = 32'h0003_FF06;
        @(posedge clk);
        mask_sh[0] = 32'h0003_FF06;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R11 same-edge compare uses old mask", {28'h0, cs_n}, 32'hF);
        @(posedge clk);
        @(negedge clk);
        check("R11 new mask applies next edge", {24'h0, cs_n, port_size, ack_delay}, 32'hE9);
        bus_strobe = 1'b0;
        write_reg(0, 1, 32'h0000_FF06);
    endtask

    task automatic t_reset_retain;
        @(negedge clk);
        bus_strobe = 1'b1; bus_addr = 32'h0001_0000; bus_fc = 4'h5;
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R1 cs_n idle in reset with strobe", {28'h0, cs_n}, 32'hF);
        bus_strobe = 1'b0;
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) base_sh[c][1:0] = 2'b00;
        read_check("R1 base ch0 keeps upper bits", 0, 0, 32'h0001_0050);
        read_check("R1 base ch1 control cleared", 1, 0, 32'h0080_0000);
        read_check("R1 mask ch1 unchanged", 1, 1, 32'h0010_0FF9);
        bus_cycle("R1 no select after reset", 32'h0001_0000, 4'h5);
        check("R1 all selects idle", {28'h0, model(32'h0001_0000, 4'h5)[7:4]}, 32'hF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        for (int c = 0; c < 4; c++) base_sh[c] = 32'h0;
        t_program();
        t_readback();
        t_addr_match();
        t_split_mask();
        t_fc_match();
        t_cpu_space();
        t_valid();
        t_priority();
        t_timing();
        t_live_mask();
        t_reset_retain();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule